// File: doc/BRIEF.md
# Bus Idle Cycle Inserter

This block sits between an external bus sequencer and the bus pins. When the sequencer reports that an access has finished, the block works out how many idle bus cycles must follow. It looks at the finished access, at the access waiting to go next, and at static per-space configuration. It loads that count into a down-counter. While the count runs, it holds the sequencer off through a ready signal and forces every chip select, strobe and DMA acknowledge to the inactive level.

Several independent rules can each ask for idle time:
- a global setting for DMA single-address transfers;
- a per-space setting chosen by the direction of the finished access and the direction of the next access;
- a per-space SDRAM gap;
- a per-space cycle for sampling the WAIT pin.

The block inserts the largest count that any applicable rule asks for. All idle cycles come after the finished access and never in front of the next one.

Top module: `bus_idle_inserter`

## Requirements
- R1: A synchronous active-high reset clears the idle counter, and seq_ready reads 1 in the cycle after reset is sampled.
- R2: A 3-bit idle code maps to cycles as 000=0, 001=1, 010=2, 011=4, 100=6, 101=8, 110=10, 111=12.
- R3: When the finished access is a DMA single-address transfer, the code cfg_dma_idle applies and the per-space direction-pair fields are ignored.
- R4: For other accesses, the direction-pair code is taken from cfg_pair_idle[(space*4+pair)*3 +: 3], where space is the finished access's space. The pair index is 0 for read then read, 1 for read then write, 2 for write then read and 3 for write then write.
- R5: A read followed by a pending read to the same space gets no idle time from the direction-pair rule.
- R6: With no pending next access, the direction-pair rule behaves as if the next access were a read to a different space.
- R7: After an SDRAM access, cfg_sdram_idle[space*2 +: 2] gives 0 to 3 idle cycles. It has no effect after a non-SDRAM access.
- R8: After a non-SDRAM access, cfg_wait_off[space]=0 adds exactly one idle cycle and 1 adds none. The bit has no effect after an SDRAM access.
- R9: The number of idle cycles inserted is the maximum over all rules that apply.
- R10: seq_ready is low for exactly N cycles, starting in the cycle after acc_done is sampled. When N is 0, seq_ready stays high, so back-to-back accesses and a continuously asserted DMA acknowledge are possible.
- R11: While seq_ready is low, bus_cs, bus_rd, bus_wr and bus_dack are 0. Otherwise they follow cs_req, rd_req, wr_req and dack_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_done | input | 1 | One-cycle pulse: the current access has finished |
| done_cs | input | CSW | Space of the finished access |
| done_wr | input | 1 | Finished access was a write |
| done_sdram | input | 1 | Finished access targeted SDRAM |
| done_dma_sa | input | 1 | Finished access was a DMA single-address transfer |
| nxt_valid | input | 1 | A next access is pending |
| nxt_cs | input | CSW | Space of the pending access |
| nxt_wr | input | 1 | Pending access is a write |
| cfg_dma_idle | input | 3 | Idle code for DMA single-address transfers |
| cfg_pair_idle | input | NCS*12 | Per-space direction-pair idle codes |
| cfg_sdram_idle | input | NCS*2 | Per-space SDRAM gap cycles |
| cfg_wait_off | input | NCS | Per-space WAIT sampling disable |
| cs_req | input | NCS | Chip selects requested by the sequencer |
| rd_req | input | 1 | Read strobe requested |
| wr_req | input | 1 | Write strobe requested |
| dack_req | input | 1 | DMA acknowledge requested |
| seq_ready | output | 1 | Sequencer may start the next access |
| bus_cs | output | NCS | Gated chip selects |
| bus_rd | output | 1 | Gated read strobe |
| bus_wr | output | 1 | Gated write strobe |
| bus_dack | output | 1 | Gated DMA acknowledge |

## Verification
The bench first aims at the rule selection:
- A design that indexed the pair fields by the next space rather than the finished one would give the wrong count for cross-space traffic.
- A design that applied the read-read gap to a same-space read would add idle time where none is due.
- A design that let the DMA rule combine with the pair fields instead of replacing them would report 12 cycles where 4 are due.

It also probes the interaction of the SDRAM gap and the WAIT cycle, where a wrong design would add the WAIT cycle to SDRAM accesses. Zero-count accesses must leave the acknowledge continuously asserted, and a wrong design would open a one-cycle gap. A reset in mid-count must release ready on the next cycle, and a wrong design would finish the old count.

// File: rtl/bic_pkg.sv
package bic_pkg;
   localparam int CODE_W = 3;
   localparam int CNT_W  = 4;
   localparam int NPAIR  = 4;
   localparam int SDR_W  = 2;

   typedef enum logic [1:0] {
      PAIR_RR = 2'd0,
      PAIR_RW = 2'd1,
      PAIR_WR = 2'd2,
      PAIR_WW = 2'd3
   } pair_e;

   // Codes 0..2 map straight through; higher codes step by two from 4.
   function automatic logic [CNT_W-1:0] code_to_cycles(input logic [CODE_W-1:0] code);
      logic [CNT_W-1:0] wide;
      wide = CNT_W'(code);
      if (code <= 3'd2) return wide;
      return CNT_W'((wide - 1'b1) << 1);
   endfunction

   function automatic pair_e pair_of(input logic prev_wr, input logic next_wr);
      return pair_e'({prev_wr, next_wr});
   endfunction
endpackage

// File: rtl/idle_code_dec.sv
module idle_code_dec
   import bic_pkg::*;
#(
   parameter int CW = CODE_W,
   parameter int OW = CNT_W
) (
   input  logic [CW-1:0] code,
   output logic [OW-1:0] cycles
);
   generate
      if (CW != CODE_W) begin : g_bad_cw
         $error("idle_code_dec: code width must match package");
      end
      if (OW < 4) begin : g_bad_ow
         $error("idle_code_dec: output must hold 12");
      end
   endgenerate

   logic [CNT_W-1:0] raw;
   always_comb raw = code_to_cycles(code);
   assign cycles = OW'(raw);

   // R2: decoded value never leaves 0..12 and small codes are literal
   always_comb begin
      a_r2_code_range: assert (raw <= CNT_W'(12));
      a_r2_low_literal: assert (code > 3'd2 || raw == CNT_W'(code));
   end
endmodule

// File: rtl/idle_cond_sel.sv
module idle_cond_sel
   import bic_pkg::*;
#(
   parameter int NCS   = 4,
   parameter int CSW   = (NCS > 1) ? $clog2(NCS) : 1,
   parameter int W     = CNT_W,
   parameter int NCOND = 4
) (
   input  logic [CSW-1:0]          done_cs,
   input  logic                    done_wr,
   input  logic                    done_sdram,
   input  logic                    done_dma_sa,
   input  logic                    nxt_valid,
   input  logic [CSW-1:0]          nxt_cs,
   input  logic                    nxt_wr,
   input  logic [CODE_W-1:0]       cfg_dma_idle,
   input  logic [NCS*NPAIR*CODE_W-1:0] cfg_pair_idle,
   input  logic [NCS*SDR_W-1:0]    cfg_sdram_idle,
   input  logic [NCS-1:0]          cfg_wait_off,
   output logic [NCOND*W-1:0]      cond_val,
   output logic [NCOND-1:0]        cond_en
);
   localparam int FLD_PER_CS = NPAIR * CODE_W;
   localparam int IDX_DMA  = 0;
   localparam int IDX_PAIR = 1;
   localparam int IDX_SDR  = 2;
   localparam int IDX_WAIT = 3;

   generate
      if (NCOND != 4) begin : g_bad_ncond
         $error("idle_cond_sel: exactly four conditions are produced");
      end
      if (W < 4) begin : g_bad_w
         $error("idle_cond_sel: count width too small");
      end
   endgenerate

   // Effective next access: missing next behaves as read to another space.
   logic  eff_nwr;
   logic  same_rr;
   pair_e pair;
   always_comb begin
      eff_nwr = nxt_valid ? nxt_wr : 1'b0;
      same_rr = nxt_valid && (nxt_cs == done_cs) && !done_wr && !nxt_wr;
      pair    = pair_of(done_wr, eff_nwr);
   end

   // Per-space field selection.
   logic [FLD_PER_CS-1:0] cs_fields;
   logic [CODE_W-1:0]     pair_code;
   logic [SDR_W-1:0]      sdr_code;
   logic                  wait_off;
   always_comb begin
      cs_fields = cfg_pair_idle[done_cs*FLD_PER_CS +: FLD_PER_CS];
      pair_code = cs_fields[pair*CODE_W +: CODE_W];
      sdr_code  = cfg_sdram_idle[done_cs*SDR_W +: SDR_W];
      wait_off  = cfg_wait_off[done_cs];
   end

   logic [W-1:0] dma_cyc;
   logic [W-1:0] pair_cyc;

   idle_code_dec #(.CW(CODE_W), .OW(W)) u_dma_dec (
      .code   (cfg_dma_idle),
      .cycles (dma_cyc)
   );

   idle_code_dec #(.CW(CODE_W), .OW(W)) u_pair_dec (
      .code   (pair_code),
      .cycles (pair_cyc)
   );

   always_comb begin
      cond_val = '0;
      cond_en  = '0;
      cond_val[IDX_DMA*W  +: W] = dma_cyc;
      cond_en[IDX_DMA]          = done_dma_sa;
      cond_val[IDX_PAIR*W +: W] = same_rr ? '0 : pair_cyc;
      cond_en[IDX_PAIR]         = !done_dma_sa;
      cond_val[IDX_SDR*W  +: W] = W'(sdr_code);
      cond_en[IDX_SDR]          = done_sdram;
      cond_val[IDX_WAIT*W +: W] = W'(1);
      cond_en[IDX_WAIT]         = !done_sdram && !wait_off;
   end

   // R3: DMA and pair rules are never both active
   always_comb begin
      a_r3_dma_excl: assert (!(cond_en[IDX_DMA] && cond_en[IDX_PAIR]));
      a_r8_wait_sdram_excl: assert (!(cond_en[IDX_SDR] && cond_en[IDX_WAIT]));
   end
endmodule

// File: rtl/idle_max.sv
module idle_max #(
   parameter int NIN = 4,
   parameter int W   = 4
) (
   input  logic [NIN*W-1:0] vals,
   input  logic [NIN-1:0]   en,
   output logic [W-1:0]     max_o
);
   generate
      if (NIN < 1) begin : g_bad_nin
         $error("idle_max: needs at least one input");
      end
   endgenerate

   logic [W-1:0] stage [NIN+1];
   assign stage[0] = '0;

   generate
      for (genvar g = 0; g < NIN; g++) begin : g_chain
         logic [W-1:0] v;
         assign v = vals[g*W +: W];
         assign stage[g+1] = (en[g] && (v > stage[g])) ? v : stage[g];
      end
   endgenerate

   assign max_o = stage[NIN];

   // R9: result dominates every enabled input
   always_comb begin
      for (int i = 0; i < NIN; i++) begin
         if (en[i]) a_r9_dominates: assert (max_o >= vals[i*W +: W]);
      end
   end
endmodule

// File: rtl/idle_counter.sv
module idle_counter #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt,
   output logic         idle
);
   generate
      if (W < 1) begin : g_bad_w
         $error("idle_counter: width must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)                 cnt <= '0;
      else if (load)           cnt <= load_val;
      else if (cnt != '0)      cnt <= cnt - 1'b1;
   end

   assign idle = (cnt != '0);

   // R10: counter steps down by one each cycle when not reloaded
   a_r10_count_down: assert property (@(posedge clk) disable iff (rst)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
   // R10: a completed access loads the requested count
   a_r10_load: assert property (@(posedge clk) disable iff (rst)
      load |=> (cnt == $past(load_val)));
   // R1: reset empties the counter
   a_r1_reset_clear: assert property (@(posedge clk)
      rst |=> (cnt == '0));
endmodule

// File: rtl/bus_idle_inserter.sv
module bus_idle_inserter
   import bic_pkg::*;
#(
   parameter int NCS = 4,
   parameter int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        acc_done,
   input  logic [CSW-1:0]              done_cs,
   input  logic                        done_wr,
   input  logic                        done_sdram,
   input  logic                        done_dma_sa,
   input  logic                        nxt_valid,
   input  logic [CSW-1:0]              nxt_cs,
   input  logic                        nxt_wr,
   input  logic [CODE_W-1:0]           cfg_dma_idle,
   input  logic [NCS*NPAIR*CODE_W-1:0] cfg_pair_idle,
   input  logic [NCS*SDR_W-1:0]        cfg_sdram_idle,
   input  logic [NCS-1:0]              cfg_wait_off,
   input  logic [NCS-1:0]              cs_req,
   input  logic                        rd_req,
   input  logic                        wr_req,
   input  logic                        dack_req,
   output logic                        seq_ready,
   output logic [NCS-1:0]              bus_cs,
   output logic                        bus_rd,
   output logic                        bus_wr,
   output logic                        bus_dack
);
   localparam int NCOND = 4;
   localparam int W     = CNT_W;

   generate
      if (NCS < 2) begin : g_bad_ncs
         $error("bus_idle_inserter: at least two spaces required");
      end
      if ((1 << CSW) < NCS) begin : g_bad_csw
         $error("bus_idle_inserter: space index too narrow");
      end
   endgenerate

   logic [NCOND*W-1:0] cond_val;
   logic [NCOND-1:0]   cond_en;
   logic [W-1:0]       need;
   logic [W-1:0]       cnt;
   logic               idle;

   idle_cond_sel #(.NCS(NCS), .CSW(CSW), .W(W), .NCOND(NCOND)) u_sel (
      .done_cs        (done_cs),
      .done_wr        (done_wr),
      .done_sdram     (done_sdram),
      .done_dma_sa    (done_dma_sa),
      .nxt_valid      (nxt_valid),
      .nxt_cs         (nxt_cs),
      .nxt_wr         (nxt_wr),
      .cfg_dma_idle   (cfg_dma_idle),
      .cfg_pair_idle  (cfg_pair_idle),
      .cfg_sdram_idle (cfg_sdram_idle),
      .cfg_wait_off   (cfg_wait_off),
      .cond_val       (cond_val),
      .cond_en        (cond_en)
   );

   idle_max #(.NIN(NCOND), .W(W)) u_max (
      .vals  (cond_val),
      .en    (cond_en),
      .max_o (need)
   );

   idle_counter #(.W(W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (acc_done),
      .load_val (need),
      .cnt      (cnt),
      .idle     (idle)
   );

   assign seq_ready = !idle;
   assign bus_cs    = cs_req & {NCS{seq_ready}};
   assign bus_rd    = rd_req & seq_ready;
   assign bus_wr    = wr_req & seq_ready;
   assign bus_dack  = dack_req & seq_ready;

   // R11: nothing reaches the pins while the idle count runs
   a_r11_quiet: assert property (@(posedge clk) disable iff (rst)
      !seq_ready |-> (bus_cs == '0 && !bus_rd && !bus_wr && !bus_dack));
   // R1: ready returns right after reset
   a_r1_ready_after_reset: assert property (@(posedge clk)
      rst |=> seq_ready);
   // R10: a zero-count completion keeps ready high
   a_r10_zero_no_gap: assert property (@(posedge clk) disable iff (rst)
      (acc_done && need == '0) |=> seq_ready);
endmodule

// File: tb/sim_bus_idle_inserter.sv
`timescale 1ns/1ps
module sim_bus_idle_inserter;
   localparam int NCS = 4;
   localparam int CSW = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;

   logic           acc_done = 0, done_wr = 0, done_sdram = 0, done_dma_sa = 0;
   logic [CSW-1:0] done_cs = 0, nxt_cs = 0;
   logic           nxt_valid = 0, nxt_wr = 0;
   logic [2:0]     cfg_dma_idle;
   logic [NCS*12-1:0] cfg_pair_idle;
   logic [NCS*2-1:0]  cfg_sdram_idle;
   logic [NCS-1:0]    cfg_wait_off;
   logic [NCS-1:0]    cs_req = '1;
   logic rd_req = 1, wr_req = 1, dack_req = 1;
   logic seq_ready, bus_rd, bus_wr, bus_dack;
   logic [NCS-1:0] bus_cs;

   int n_chk = 0, n_fail = 0;

   bus_idle_inserter #(.NCS(NCS), .CSW(CSW)) u0 (.*);

   // Pair codes per space, order RR,RW,WR,WW (R4)
   initial begin
      cfg_dma_idle = 3'b011;                       // 4 cycles
      cfg_pair_idle = '0;
      cfg_pair_idle[0*12 +: 12] = {3'd0, 3'd2, 3'd1, 3'd4}; // WW,WR,RW,RR
      cfg_pair_idle[1*12 +: 12] = {3'd6, 3'd3, 3'd5, 3'd7};
      cfg_pair_idle[2*12 +: 12] = {3'd0, 3'd0, 3'd0, 3'd0};
      cfg_pair_idle[3*12 +: 12] = {3'd1, 3'd0, 3'd2, 3'd0};
      cfg_sdram_idle = {2'd1, 2'd3, 2'd0, 2'd2};   // sp3..sp0
      cfg_wait_off   = 4'b0110;
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Issue one completion and count idle cycles; also check pin gating.
   task automatic run_acc(input logic [1:0] cs, input logic wr, input logic sd,
                          input logic dma, input logic nv, input logic [1:0] ncs,
                          input logic nwr, output int n, output int leak);
      @(negedge clk);
      done_cs = cs; done_wr = wr; done_sdram = sd; done_dma_sa = dma;
      nxt_valid = nv; nxt_cs = ncs; nxt_wr = nwr; acc_done = 1;
      @(negedge clk);
      acc_done = 0;
      n = 0; leak = 0;
      while (!seq_ready && n < 20) begin
         n++;
         if (bus_cs != 0 || bus_rd || bus_wr || bus_dack) leak++;
         @(negedge clk);
      end
   endtask

   // {cs, wr, sdram, dma, nvalid, ncs, nwr, expected}
   localparam logic [12:0] VEC [15] = '{
      {2'd0,1'b0,1'b0,1'b0,1'b1,2'd1,1'b0,4'd6},   // R2 R4 code 100
      {2'd0,1'b0,1'b0,1'b0,1'b1,2'd0,1'b0,4'd1},   // R5 same space RR
      {2'd0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,4'd6},   // R6 no next
      {2'd0,1'b0,1'b0,1'b0,1'b1,2'd2,1'b1,4'd1},   // R4 RW
      {2'd0,1'b1,1'b0,1'b0,1'b1,2'd1,1'b0,4'd2},   // R4 WR
      {2'd1,1'b0,1'b0,1'b0,1'b1,2'd2,1'b0,4'd12},  // R2 code 111
      {2'd1,1'b1,1'b0,1'b0,1'b1,2'd0,1'b1,4'd10},  // R2 code 110
      {2'd1,1'b0,1'b0,1'b0,1'b1,2'd3,1'b1,4'd8},   // R2 code 101
      {2'd1,1'b1,1'b0,1'b0,1'b1,2'd3,1'b0,4'd4},   // R2 code 011
      {2'd2,1'b1,1'b0,1'b0,1'b1,2'd0,1'b0,4'd0},   // R8 wait off, zero
      {2'd2,1'b0,1'b1,1'b0,1'b1,2'd0,1'b0,4'd3},   // R7 sdram 3
      {2'd0,1'b1,1'b1,1'b0,1'b1,2'd0,1'b1,4'd2},   // R7 R8 sdram, no wait
      {2'd1,1'b0,1'b0,1'b1,1'b1,2'd0,1'b0,4'd4},   // R3 dma overrides 12
      {2'd3,1'b1,1'b0,1'b0,1'b1,2'd3,1'b1,4'd1},   // R8 wait cycle
      {2'd3,1'b0,1'b1,1'b0,1'b1,2'd0,1'b1,4'd2}    // R9 max(pair 2, sdram 1)
   };

   initial begin
      int n, leak;
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      check("R1 ready after reset", seq_ready, 1);
      check("R11 pass-through when ready", bus_cs, 4'hF);

      for (int i = 0; i < 15; i++) begin
         run_acc(VEC[i][12:11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7],
                 VEC[i][6:5], VEC[i][4], n, leak);
         check($sformatf("R9 R10 vector %0d idle count", i), n, int'(VEC[i][3:0]));
         check($sformatf("R11 vector %0d gating", i), leak, 0);
      end

      // R3 / R10: DMA code 0 gives no gap, acknowledge stays up
      cfg_dma_idle = 3'b000;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         done_cs = 2; done_wr = 1; done_sdram = 0; done_dma_sa = 1;
         nxt_valid = 1; nxt_cs = 2; nxt_wr = 1; acc_done = 1;
         @(negedge clk);
         acc_done = 0;
         check("R10 dack continuous with zero DMA count", bus_dack, 1);
      end
      // R2 code 010 through DMA field
      cfg_dma_idle = 3'b010;
      run_acc(2, 1, 0, 1, 1, 2, 1, n, leak);
      check("R2 code 010 gives 2", n, 2);
      // R2 code 001
      cfg_dma_idle = 3'b001;
      run_acc(2, 1, 0, 1, 1, 2, 1, n, leak);
      check("R2 code 001 gives 1", n, 1);

      // R1: reset in mid-count releases ready next cycle
      @(negedge clk);
      done_cs = 1; done_wr = 0; done_sdram = 0; done_dma_sa = 0;
      nxt_valid = 1; nxt_cs = 2; nxt_wr = 0; acc_done = 1;
      @(negedge clk);
      acc_done = 0;
      @(negedge clk);
      check("R10 idle running before reset", seq_ready, 0);
      rst = 1;
      @(negedge clk);
      rst = 0;
      check("R1 reset clears count", seq_ready, 1);
      check("R11 pins restored after reset", bus_dack, 1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule